// File: doc/BRIEF.md
# Interrupt Pending and Priority Controller

This block holds the pending state, the active state and a two-bit priority for each of 32 external interrupt lines. Software reaches it through a simple word-addressed register port. It sees one pending vector through two windows. Writing ones to the set window marks interrupts pending. Writing ones to the clear window removes the pending state. Writing zeros to either window has no effect. Eight priority words each carry four byte-wide priority fields, and only the top two bits of each field are stored.

Hardware request lines raise pending on a rising level. A per-line enable input decides which pending interrupts may compete. Every cycle the block picks the most urgent interrupt that is both pending and enabled, and presents its number with a valid flag from a register. An acknowledge input moves an interrupt from pending to active. A completion input retires it from active.

Top module: `irq_pend_prio_ctrl`

## Requirements
- R1: After reset every pending bit, every active bit and every priority field is zero, and `best_valid` is 0.
- R2: A write to offset 0x200 makes interrupt i pending for every written bit i that is 1, whether or not `irq_enable[i]` is set. Bits written as 0 leave the pending state unchanged.
- R3: A write to offset 0x280 clears pending for every written bit i that is 1, and bits written as 0 have no effect. Such a write never changes `irq_active`.
- R4: A read of offset 0x200 or 0x280 returns the pending vector, with bit i for interrupt i. A read of any unmapped offset returns 0.
- R5: The priority word n sits at offset 0x400 + 4*n (n = 0..7). Byte k, bits [8k+7:8k], belongs to interrupt 4n+k. Only bits [8k+7:8k+6] are stored, and the other six bits read as zero, so writing 0xFF reads back 0xC0. A write changes only the byte lanes whose `reg_wstrb` bit is 1, and this lane gating also applies to the pending windows.
- R6: A 0-to-1 change on `irq_lines[i]` makes interrupt i pending at the next clock edge. A line held high does not set the bit again after it has been cleared. When a rising level and a software or acknowledge clear hit the same bit in the same cycle, the bit ends up pending.
- R7: One clock edge after the pending state or the enables change, `best_valid` and `best_id` show the pending and enabled interrupt with the numerically lowest priority value. On equal priority, the lowest interrupt number wins.
- R8: An acknowledge (`ack_valid` with `ack_id`) clears that interrupt's pending bit and sets its bit in `irq_active` at the next edge.
- R9: A completion (`done_valid` with `done_id`) clears that interrupt's active bit. If an acknowledge for the same interrupt arrives in the same cycle, the active bit ends up set.
- R10: A pending interrupt whose enable is 0 keeps its pending bit but is never reported as the winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte offset of the accessed word |
| reg_wdata | input | 32 | Write data |
| reg_wstrb | input | 4 | Byte-lane write enables |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_lines | input | 32 | Hardware interrupt request levels |
| irq_enable | input | 32 | Per-interrupt enable |
| ack_valid | input | 1 | Acknowledge strobe |
| ack_id | input | 5 | Interrupt number being acknowledged |
| done_valid | input | 1 | Completion strobe |
| done_id | input | 5 | Interrupt number being completed |
| best_valid | output | 1 | A pending enabled interrupt exists |
| best_id | output | 5 | Number of the most urgent pending enabled interrupt |
| irq_active | output | 32 | Active state per interrupt |

## Verification
Arbitration is tried with several pending sets. A set whose members all differ in priority shows that the priority value decides the winner. Adding an equal-priority interrupt with a lower number shows the tie-break. Disabling the current winner shows that enable gating works without losing the pending bit. A pending set that is entirely disabled confirms that no winner is reported. Priority writes with a full strobe and with single-lane strobes tell apart correct top-bit truncation and correct lane isolation. Hardware requests are driven as a fresh edge, as a held level after a clear, and as an edge that coincides with a clear, which tells edge-triggered setting apart from level setting and shows the set-over-clear rule.

// File: rtl/irq_pc_pkg.sv
package irq_pc_pkg;

    localparam logic [11:0] OFS_SETPEND   = 12'h200;
    localparam logic [11:0] OFS_CLRPEND   = 12'h280;
    localparam logic [11:0] OFS_PRIO_BASE = 12'h400;
    localparam int          LANE_W        = 8;
    localparam int          LANES         = 4;

    function automatic logic [LANES*LANE_W-1:0] lane_mask(input logic [LANES-1:0] strb);
        logic [LANES*LANE_W-1:0] m;
        for (int k = 0; k < LANES; k++) begin
            m[k*LANE_W +: LANE_W] = {LANE_W{strb[k]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    parameter int IDX_W   = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [3:0]                wr_strb,
    input  logic [4*PRIO_W-1:0]       wr_hi,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [31:0]               rd_word,
    output logic [NUM_IRQ*PRIO_W-1:0] prio_flat
);
    logic [PRIO_W-1:0] fld_q [NUM_IRQ];
    logic [PRIO_W-1:0] fld_d [NUM_IRQ];

    always_comb begin
        fld_d = fld_q;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (wr_en && wr_idx == IDX_W'(i / 4) && wr_strb[i % 4]) begin
                fld_d[i] = wr_hi[(i % 4)*PRIO_W +: PRIO_W];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (rd_idx == IDX_W'(i / 4)) begin
                rd_word[(i % 4)*8 + 7 -: PRIO_W] = fld_q[i];
            end
        end
    end

    for (genvar g = 0; g < NUM_IRQ; g++) begin : g_flat
        assign prio_flat[g*PRIO_W +: PRIO_W] = fld_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IRQ; i++) fld_q[i] <= '0;
        end else begin
            fld_q <= fld_d;
        end
    end
endmodule

// File: rtl/irq_pick_arbiter.sv
module irq_pick_arbiter #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    parameter int ID_W    = 5
) (
    input  logic [NUM_IRQ-1:0]        elig,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio_flat,
    output logic                      found,
    output logic [ID_W-1:0]           win_id
);
    logic [PRIO_W-1:0] win_prio;

    // Strict less-than keeps the lowest index on equal priority.
    always_comb begin
        found    = 1'b0;
        win_id   = '0;
        win_prio = '1;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (elig[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < win_prio)) begin
                found    = 1'b1;
                win_id   = ID_W'(i);
                win_prio = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irq_pend_prio_ctrl.sv
module irq_pend_prio_ctrl #(
    parameter int NUM_IRQ = 32,
    parameter int PRIO_W  = 2,
    parameter int ADDR_W  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_we,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [31:0]             reg_wdata,
    input  logic [3:0]              reg_wstrb,
    output logic [31:0]             reg_rdata,
    input  logic [NUM_IRQ-1:0]      irq_lines,
    input  logic [NUM_IRQ-1:0]      irq_enable,
    input  logic                    ack_valid,
    input  logic [$clog2(NUM_IRQ)-1:0] ack_id,
    input  logic                    done_valid,
    input  logic [$clog2(NUM_IRQ)-1:0] done_id,
    output logic                    best_valid,
    output logic [$clog2(NUM_IRQ)-1:0] best_id,
    output logic [NUM_IRQ-1:0]      irq_active
);
    import irq_pc_pkg::*;

    localparam int ID_W       = $clog2(NUM_IRQ);
    localparam int NUM_PREG   = NUM_IRQ / 4;
    localparam int PREG_IDX_W = (NUM_PREG > 1) ? $clog2(NUM_PREG) : 1;

    typedef struct packed {
        logic [NUM_IRQ-1:0] pend;
        logic [NUM_IRQ-1:0] active;
        logic [NUM_IRQ-1:0] line_prev;
        logic               best_valid;
        logic [ID_W-1:0]    best_id;
    } ctl_t;

    ctl_t st_q, st_d;

    logic [NUM_IRQ-1:0]        pend_now;
    logic [31:0]               lanes;
    logic [NUM_IRQ-1:0]        wbits;
    logic                      set_sel, clr_sel, prio_sel;
    logic [ADDR_W-1:0]         prio_ofs;
    logic [PREG_IDX_W-1:0]     prio_idx;
    logic [4*PRIO_W-1:0]       lane_hi;
    logic [31:0]               prio_rd_word;
    logic [NUM_IRQ*PRIO_W-1:0] prio_flat;
    logic                      arb_found;
    logic [ID_W-1:0]           arb_id;
    logic [NUM_IRQ-1:0]        rise, sw_set, sw_clr, ack_mask, done_mask;

    assign pend_now = st_q.pend;
    assign lanes    = lane_mask(reg_wstrb);
    assign wbits    = reg_wdata[NUM_IRQ-1:0] & lanes[NUM_IRQ-1:0];

    // Address decode
    assign set_sel  = reg_addr == ADDR_W'(OFS_SETPEND);
    assign clr_sel  = reg_addr == ADDR_W'(OFS_CLRPEND);
    assign prio_ofs = reg_addr - ADDR_W'(OFS_PRIO_BASE);
    assign prio_sel = (reg_addr >= ADDR_W'(OFS_PRIO_BASE))
                   && (prio_ofs < ADDR_W'(4 * NUM_PREG))
                   && (prio_ofs[1:0] == 2'b00);
    assign prio_idx = prio_ofs[PREG_IDX_W+1:2];

    for (genvar k = 0; k < 4; k++) begin : g_lane
        assign lane_hi[k*PRIO_W +: PRIO_W] = reg_wdata[k*8 + 7 -: PRIO_W];
    end

    irq_prio_bank #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .IDX_W   (PREG_IDX_W)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_we && prio_sel),
        .wr_idx    (prio_idx),
        .wr_strb   (reg_wstrb),
        .wr_hi     (lane_hi),
        .rd_idx    (prio_idx),
        .rd_word   (prio_rd_word),
        .prio_flat (prio_flat)
    );

    irq_pick_arbiter #(
        .NUM_IRQ (NUM_IRQ),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
    ) u_arb (
        .elig      (st_q.pend & irq_enable),
        .prio_flat (prio_flat),
        .found     (arb_found),
        .win_id    (arb_id)
    );

    always_comb begin
        st_d      = st_q;
        rise      = irq_lines & ~st_q.line_prev;
        sw_set    = (reg_we && set_sel) ? wbits : '0;
        sw_clr    = (reg_we && clr_sel) ? wbits : '0;
        ack_mask  = ack_valid  ? (NUM_IRQ'(1) << ack_id)  : '0;
        done_mask = done_valid ? (NUM_IRQ'(1) << done_id) : '0;

        st_d.line_prev  = irq_lines;
        // A hardware rising level overrides any clear in the same cycle.
        st_d.pend       = ((st_q.pend | sw_set) & ~sw_clr & ~ack_mask) | rise;
        // Acknowledge overrides a completion for the same interrupt.
        st_d.active     = (st_q.active & ~done_mask) | ack_mask;
        st_d.best_valid = arb_found;
        st_d.best_id    = arb_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (set_sel || clr_sel) reg_rdata = 32'(pend_now);
        else if (prio_sel)      reg_rdata = prio_rd_word;
    end

    assign best_valid = st_q.best_valid;
    assign best_id    = st_q.best_id;
    assign irq_active = st_q.active;
endmodule

// File: rtl/irq_pc_checker.sv
module irq_pc_checker #(
    parameter int NUM_IRQ = 32,
    parameter int ADDR_W  = 12,
    parameter int ID_W    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_we,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [31:0]        reg_rdata,
    input logic [NUM_IRQ-1:0] irq_lines,
    input logic [NUM_IRQ-1:0] irq_enable,
    input logic               ack_valid,
    input logic [ID_W-1:0]    ack_id,
    input logic               done_valid,
    input logic [ID_W-1:0]    done_id,
    input logic               best_valid,
    input logic [ID_W-1:0]    best_id,
    input logic [NUM_IRQ-1:0] irq_active,
    input logic [NUM_IRQ-1:0] pend_now
);
    logic [NUM_IRQ-1:0] lines_seen_q, elig_seen_q, rise_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lines_seen_q <= '0;
            elig_seen_q  <= '0;
        end else begin
            lines_seen_q <= irq_lines;
            elig_seen_q  <= pend_now & irq_enable;
        end
    end

    assign rise_c = irq_lines & ~lines_seen_q;

    AST_PRIO_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr >= ADDR_W'(12'h400) && reg_addr < ADDR_W'(12'h400 + NUM_IRQ))
        |-> ((reg_rdata & 32'h3F3F3F3F) == 32'h0)); // R5

    AST_RISE_SETS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_c != '0) |=> ((pend_now & $past(rise_c)) == $past(rise_c))); // R6

    AST_CLEAR_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_W'(12'h280) && !ack_valid && !done_valid)
        |=> $stable(irq_active)); // R3

    AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        best_valid |-> elig_seen_q[best_id]); // R7

    AST_NO_WINNER_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_seen_q == '0) |-> !best_valid); // R10

    AST_ACK_SETS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> irq_active[$past(ack_id)]); // R8

    AST_DONE_CLEARS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !(ack_valid && ack_id == done_id))
        |=> !irq_active[$past(done_id)]); // R9
endmodule

bind irq_pend_prio_ctrl irq_pc_checker #(
    .NUM_IRQ (NUM_IRQ),
    .ADDR_W  (ADDR_W),
    .ID_W    (ID_W)
) u_chk (.*);

// File: tb/test_irq_pend_prio_ctrl.sv
`timescale 1ns/1ps
module test_irq_pend_prio_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_wstrb = '0;
    logic [31:0] reg_rdata;
    logic [31:0] irq_lines = '0;
    logic [31:0] irq_enable = '0;
    logic        ack_valid = 1'b0;
    logic [4:0]  ack_id = '0;
    logic        done_valid = 1'b0;
    logic [4:0]  done_id = '0;
    logic        best_valid;
    logic [4:0]  best_id;
    logic [31:0] irq_active;

    int n_chk = 0;
    int n_fail = 0;
    logic finished = 1'b0;

    always #2 clk = ~clk;

    irq_pend_prio_ctrl i_irq_pend_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_wstrb(reg_wstrb), .reg_rdata(reg_rdata),
        .irq_lines(irq_lines), .irq_enable(irq_enable),
        .ack_valid(ack_valid), .ack_id(ack_id),
        .done_valid(done_valid), .done_id(done_id),
        .best_valid(best_valid), .best_id(best_id), .irq_active(irq_active)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d; reg_wstrb = s;
        @(negedge clk);
        reg_we = 1'b0; reg_wstrb = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 best_valid", 32'(best_valid), 32'h0);
        chk("R1 active", irq_active, 32'h0);
        rd(12'h200, v); chk("R1 pending", v, 32'h0);
        rd(12'h41C, v); chk("R1 prio", v, 32'h0);
    endtask

    task automatic t_set_clear();
        logic [31:0] v;
        wr(12'h200, 32'h0000_0011, 4'hF);
        rd(12'h280, v); chk("R2 set while disabled / R4 alias", v, 32'h11);
        wr(12'h200, 32'h0, 4'hF);
        rd(12'h200, v); chk("R2 zero write", v, 32'h11);
        wr(12'h280, 32'h1, 4'hF);
        rd(12'h200, v); chk("R3 clear", v, 32'h10);
        wr(12'h280, 32'h0, 4'hF);
        rd(12'h200, v); chk("R3 zero write", v, 32'h10);
        chk("R10 disabled not reported", 32'(best_valid), 32'h0);
        @(negedge clk); irq_enable = 32'h10;
        @(negedge clk);
        chk("R7 single winner valid", 32'(best_valid), 32'h1);
        chk("R7 single winner id", 32'(best_id), 32'd4);
        rd(12'h300, v); chk("R4 unmapped reads zero", v, 32'h0);
    endtask

    task automatic t_prio();
        logic [31:0] v;
        wr(12'h400, 32'hFFFF_FFFF, 4'hF);
        rd(12'h400, v); chk("R5 truncation", v, 32'hC0C0_C0C0);
        wr(12'h404, 32'h0000_4000, 4'b0010);
        rd(12'h404, v); chk("R5 byte lane 1", v, 32'h0000_4000);
        wr(12'h404, 32'hFFFF_FFFF, 4'b0001);
        rd(12'h404, v); chk("R5 byte lane 0 only", v, 32'h0000_40C0);
        wr(12'h200, 32'h0000_FF00, 4'b0001);
        rd(12'h200, v); chk("R5 strobe gates pending window", v, 32'h10);
    endtask

    task automatic t_arb();
        logic [31:0] v;
        @(negedge clk); irq_enable = 32'hFFFF_FFFF;
        wr(12'h280, 32'hFFFF_FFFF, 4'hF);
        wr(12'h200, 32'h0000_0031, 4'hF);
        @(negedge clk);
        chk("R7 lowest value wins", 32'(best_id), 32'd5);
        wr(12'h200, 32'h0000_0200, 4'hF);
        @(negedge clk);
        chk("R7 priority zero wins", 32'(best_id), 32'd9);
        wr(12'h200, 32'h0000_0100, 4'hF);
        @(negedge clk);
        chk("R7 tie lower number", 32'(best_id), 32'd8);
        @(negedge clk); irq_enable[8] = 1'b0;
        @(negedge clk);
        chk("R10 disabled winner skipped", 32'(best_id), 32'd9);
        rd(12'h280, v); chk("R10 pending kept", v, 32'h331);
    endtask

    task automatic t_ack();
        logic [31:0] v;
        @(negedge clk); ack_valid = 1'b1; ack_id = 5'd8;
        @(negedge clk); ack_valid = 1'b0;
        chk("R8 active set", irq_active, 32'h100);
        rd(12'h200, v); chk("R8 pending cleared", v, 32'h231);
        wr(12'h280, 32'h0000_0120, 4'hF);
        chk("R3 active unchanged", irq_active, 32'h100);
        rd(12'h200, v); chk("R3 clear with active", v, 32'h211);
        @(negedge clk); done_valid = 1'b1; done_id = 5'd8;
        @(negedge clk); done_valid = 1'b0;
        chk("R9 done clears", irq_active, 32'h0);
        @(negedge clk); done_valid = 1'b1; done_id = 5'd5; ack_valid = 1'b1; ack_id = 5'd5;
        @(negedge clk); done_valid = 1'b0; ack_valid = 1'b0;
        chk("R9 ack beats done", irq_active, 32'h20);
    endtask

    task automatic t_hw();
        logic [31:0] v;
        wr(12'h280, 32'hFFFF_FFFF, 4'hF);
        @(negedge clk); irq_lines[3] = 1'b1;
        @(negedge clk);
        rd(12'h200, v); chk("R6 rising sets", v, 32'h8);
        wr(12'h280, 32'h8, 4'hF);
        @(negedge clk);
        rd(12'h200, v); chk("R6 held level no reset", v, 32'h0);
        @(negedge clk); irq_lines[3] = 1'b0;
        @(negedge clk);
        irq_lines[3] = 1'b1;
        reg_we = 1'b1; reg_addr = 12'h280; reg_wdata = 32'h8; reg_wstrb = 4'hF;
        @(negedge clk); reg_we = 1'b0;
        rd(12'h200, v); chk("R6 set beats clear", v, 32'h8);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_prio();
        t_arb();
        t_ack();
        t_hw();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule